// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a processor core. The lower eight registers exist twice, as bank 0 and bank 1. The upper eight exist once and are shared by every mode. The processor supplies a privileged-mode flag and a bank-select status bit. From these two inputs a small view decoder picks one of three named views: `VIEW_USER`, `VIEW_PRIV_B0` and `VIEW_PRIV_B1`. The view decides which copy of the lower registers the normal ports see.

The normal side has two combinational read ports and one synchronous write port, each addressed by a 4-bit register number. A dedicated output always presents the visible R0, which the address generator uses as an index register. An alternate-bank port lets control-register load and store instructions reach the copy that the normal ports cannot see. This port is honoured only in privileged mode.

The view is combinational, so it has no state register. Its transitions are immediate and follow the inputs:
- `VIEW_USER` is selected whenever the privileged flag is low.
- `VIEW_PRIV_B0` is selected when the flag is high and the select bit is 0.
- `VIEW_PRIV_B1` is selected when the flag is high and the select bit is 1.

All 24 physical registers clear on an asynchronous active-low reset.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every register reads zero through every read port, in every view.
- R2: Register numbers 8 to 15 (bit 3 of the address set) address one shared copy. A value written there reads back the same in all three views.
- R3: In `VIEW_USER` (privileged flag low), register numbers 0 to 7 use bank 0, whatever the value of the bank-select bit.
- R4: In `VIEW_PRIV_B1` (flag high, select 1), register numbers 0 to 7 use bank 1, and the alternate-bank port reads and writes bank 0.
- R5: In `VIEW_PRIV_B0` (flag high, select 0), register numbers 0 to 7 use bank 0, and the alternate-bank port reads and writes bank 1.
- R6: `idx_r0_o` always equals the value that a normal read of register 0 returns in the same cycle, including the write-first case.
- R7: When an alternate-bank request arrives with the privileged flag low, `alt_illegal_o` is 1 and any write is dropped. `alt_rdata_o` is 0 whenever no request is accepted.
- R8: A normal read whose address equals the address of an active normal write in the same cycle returns the new write data.
- R9: An accepted alternate-bank write returns its own write data on `alt_rdata_o` in the same cycle.
- R10: Normal-port writes never change the hidden bank. Its contents survive any sequence of mode and bank-select changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_i | input | 1 | Processor is in privileged mode |
| bank_sel_i | input | 1 | Bank-select status bit |
| rd_a_addr_i | input | 4 | Read port A register number |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 4 | Read port B register number |
| rd_b_data_o | output | 32 | Read port B data |
| idx_r0_o | output | 32 | Currently visible R0 |
| wr_en_i | input | 1 | Normal write enable |
| wr_addr_i | input | 4 | Normal write register number |
| wr_data_i | input | 32 | Normal write data |
| alt_req_i | input | 1 | Alternate-bank access request |
| alt_we_i | input | 1 | Alternate-bank access is a write |
| alt_addr_i | input | 3 | Alternate-bank register index 0 to 7 |
| alt_wdata_i | input | 32 | Alternate-bank write data |
| alt_rdata_o | output | 32 | Alternate-bank read data |
| alt_illegal_o | output | 1 | Alternate request made outside privileged mode |

## Verification
The hardest condition to reach is a hidden bank that holds distinct, known data while the view changes repeatedly. A fault that leaks a normal write into the wrong copy only shows up after a later switch exposes that copy. The stimulus first fills every bank through both ports with values that encode the bank and the index. It then hammers the visible copy with normal writes under each view. Afterwards it reads the other copy back through the alternate port and through a view change. A long randomised phase follows, in which every cycle switches mode and bank bit and mixes both ports, including user-mode alternate writes.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

    // Register view chosen by privilege and bank select
    typedef enum logic [1:0] {
        VIEW_USER    = 2'd0,
        VIEW_PRIV_B0 = 2'd1,
        VIEW_PRIV_B1 = 2'd2
    } view_e;

endpackage

// File: rtl/brf_view.sv
module brf_view
    import banked_regfile_pkg::*;
(
    input  logic priv_i,
    input  logic bank_sel_i,
    output logic vis_bank_o,
    output logic alt_ok_o
);

    view_e view;

    always_comb begin
        if (!priv_i)        view = VIEW_USER;
        else if (bank_sel_i) view = VIEW_PRIV_B1;
        else                view = VIEW_PRIV_B0;
    end

    always_comb begin
        unique case (view)
            VIEW_USER: begin
                vis_bank_o = 1'b0;
                alt_ok_o   = 1'b0;
            end
            VIEW_PRIV_B0: begin
                vis_bank_o = 1'b0;
                alt_ok_o   = 1'b1;
            end
            VIEW_PRIV_B1: begin
                vis_bank_o = 1'b1;
                alt_ok_o   = 1'b1;
            end
            default: begin
                vis_bank_o = 1'b0;
                alt_ok_o   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/brf_store.sv
module brf_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_a_i,
    input  logic [AW-1:0]                 addr_a_i,
    input  logic [DATA_W-1:0]             data_a_i,
    input  logic                          we_b_i,
    input  logic [AW-1:0]                 addr_b_i,
    input  logic [DATA_W-1:0]             data_b_i,
    output logic [DEPTH-1:0][DATA_W-1:0]  mem_o
);

    // Port A (normal write) has priority over port B (alternate write)
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_o[i] <= '0;
            else if (we_a_i && addr_a_i == AW'(i))
                mem_o[i] <= data_a_i;
            else if (we_b_i && addr_b_i == AW'(i))
                mem_o[i] <= data_b_i;
        end
    end

endmodule

// File: rtl/brf_read.sv
module brf_read #(
    parameter int BANK_REGS = 8,
    parameter int DATA_W    = 32,
    localparam int LO_AW    = $clog2(BANK_REGS),
    localparam int ADDR_W   = LO_AW + 1
) (
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [BANK_REGS-1:0][DATA_W-1:0] b0_i,
    input  logic [BANK_REGS-1:0][DATA_W-1:0] b1_i,
    input  logic [BANK_REGS-1:0][DATA_W-1:0] hi_i,
    input  logic                             vis_bank_i,
    input  logic                             byp_en_i,
    input  logic [ADDR_W-1:0]                byp_addr_i,
    input  logic [DATA_W-1:0]                byp_data_i,
    output logic [DATA_W-1:0]                data_o
);

    logic [LO_AW-1:0] idx;
    assign idx = addr_i[LO_AW-1:0];

    always_comb begin
        if (byp_en_i && byp_addr_i == addr_i)
            data_o = byp_data_i;
        else if (addr_i[ADDR_W-1])
            data_o = hi_i[idx];
        else if (vis_bank_i)
            data_o = b1_i[idx];
        else
            data_o = b0_i[idx];
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
    parameter int BANK_REGS = 8,
    parameter int DATA_W    = 32,
    localparam int LO_AW    = $clog2(BANK_REGS),
    localparam int ADDR_W   = LO_AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              priv_i,
    input  logic              bank_sel_i,
    input  logic [ADDR_W-1:0] rd_a_addr_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [ADDR_W-1:0] rd_b_addr_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    output logic [DATA_W-1:0] idx_r0_o,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              alt_req_i,
    input  logic              alt_we_i,
    input  logic [LO_AW-1:0]  alt_addr_i,
    input  logic [DATA_W-1:0] alt_wdata_i,
    output logic [DATA_W-1:0] alt_rdata_o,
    output logic              alt_illegal_o
);

    logic vis_bank, alt_ok, alt_go, alt_wr, wr_lo, wr_hi;
    logic [BANK_REGS-1:0][DATA_W-1:0] b0_q, b1_q, hi_q;
    logic [DATA_W-1:0] alt_mem;

    brf_view u_view (
        .priv_i     (priv_i),
        .bank_sel_i (bank_sel_i),
        .vis_bank_o (vis_bank),
        .alt_ok_o   (alt_ok)
    );

    assign wr_lo  = wr_en_i && !wr_addr_i[ADDR_W-1];
    assign wr_hi  = wr_en_i &&  wr_addr_i[ADDR_W-1];
    assign alt_go = alt_req_i && alt_ok;
    assign alt_wr = alt_go && alt_we_i;

    brf_store #(.DEPTH(BANK_REGS), .DATA_W(DATA_W)) u_bank0 (
        .clk(clk), .rst_n(rst_n),
        .we_a_i(wr_lo && !vis_bank), .addr_a_i(wr_addr_i[LO_AW-1:0]), .data_a_i(wr_data_i),
        .we_b_i(alt_wr && vis_bank), .addr_b_i(alt_addr_i), .data_b_i(alt_wdata_i),
        .mem_o(b0_q)
    );

    brf_store #(.DEPTH(BANK_REGS), .DATA_W(DATA_W)) u_bank1 (
        .clk(clk), .rst_n(rst_n),
        .we_a_i(wr_lo && vis_bank), .addr_a_i(wr_addr_i[LO_AW-1:0]), .data_a_i(wr_data_i),
        .we_b_i(alt_wr && !vis_bank), .addr_b_i(alt_addr_i), .data_b_i(alt_wdata_i),
        .mem_o(b1_q)
    );

    brf_store #(.DEPTH(BANK_REGS), .DATA_W(DATA_W)) u_high (
        .clk(clk), .rst_n(rst_n),
        .we_a_i(wr_hi), .addr_a_i(wr_addr_i[LO_AW-1:0]), .data_a_i(wr_data_i),
        .we_b_i(1'b0), .addr_b_i('0), .data_b_i('0),
        .mem_o(hi_q)
    );

    brf_read #(.BANK_REGS(BANK_REGS), .DATA_W(DATA_W)) u_rd_a (
        .addr_i(rd_a_addr_i), .b0_i(b0_q), .b1_i(b1_q), .hi_i(hi_q),
        .vis_bank_i(vis_bank), .byp_en_i(wr_en_i), .byp_addr_i(wr_addr_i),
        .byp_data_i(wr_data_i), .data_o(rd_a_data_o)
    );

    brf_read #(.BANK_REGS(BANK_REGS), .DATA_W(DATA_W)) u_rd_b (
        .addr_i(rd_b_addr_i), .b0_i(b0_q), .b1_i(b1_q), .hi_i(hi_q),
        .vis_bank_i(vis_bank), .byp_en_i(wr_en_i), .byp_addr_i(wr_addr_i),
        .byp_data_i(wr_data_i), .data_o(rd_b_data_o)
    );

    brf_read #(.BANK_REGS(BANK_REGS), .DATA_W(DATA_W)) u_rd_idx (
        .addr_i('0), .b0_i(b0_q), .b1_i(b1_q), .hi_i(hi_q),
        .vis_bank_i(vis_bank), .byp_en_i(wr_en_i), .byp_addr_i(wr_addr_i),
        .byp_data_i(wr_data_i), .data_o(idx_r0_o)
    );

    // Alternate port sees the copy the normal ports do not
    assign alt_mem       = vis_bank ? b0_q[alt_addr_i] : b1_q[alt_addr_i];
    assign alt_rdata_o   = !alt_go ? '0 : (alt_we_i ? alt_wdata_i : alt_mem);
    assign alt_illegal_o = alt_req_i && !priv_i;

    // R3
    user_low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !priv_i && !wr_addr_i[ADDR_W-1])
        |=> b0_q[$past(wr_addr_i[LO_AW-1:0])] == $past(wr_data_i));

    // R2
    shared_high_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i[ADDR_W-1])
        |=> hi_q[$past(wr_addr_i[LO_AW-1:0])] == $past(wr_data_i));

    // R7
    user_alt_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_req_i && alt_we_i && !priv_i) |=> $stable(b1_q));

    // R10
    hidden_bank0_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_i && bank_sel_i && !(alt_req_i && alt_we_i)) |=> $stable(b0_q));

    // R10
    hidden_bank1_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(priv_i && bank_sel_i) && !(alt_req_i && alt_we_i)) |=> $stable(b1_q));

    // R6
    index_r0_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr_i == '0) |-> (idx_r0_o == rd_a_data_o));

endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        priv_i = 1'b0, bank_sel_i = 1'b0;
    logic [3:0]  rd_a_addr_i = '0, rd_b_addr_i = '0, wr_addr_i = '0;
    logic [31:0] rd_a_data_o, rd_b_data_o, idx_r0_o, wr_data_i = '0;
    logic        wr_en_i = 1'b0, alt_req_i = 1'b0, alt_we_i = 1'b0;
    logic [2:0]  alt_addr_i = '0;
    logic [31:0] alt_wdata_i = '0, alt_rdata_o;
    logic        alt_illegal_o;

    int checks = 0;
    int fails  = 0;
    string tag_ovr = "";

    logic [31:0] m_b0 [8];
    logic [31:0] m_b1 [8];
    logic [31:0] m_hi [8];

    always #10 clk = ~clk;

    banked_regfile uut (
        .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .bank_sel_i(bank_sel_i),
        .rd_a_addr_i(rd_a_addr_i), .rd_a_data_o(rd_a_data_o),
        .rd_b_addr_i(rd_b_addr_i), .rd_b_data_o(rd_b_data_o),
        .idx_r0_o(idx_r0_o), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .alt_req_i(alt_req_i), .alt_we_i(alt_we_i),
        .alt_addr_i(alt_addr_i), .alt_wdata_i(alt_wdata_i),
        .alt_rdata_o(alt_rdata_o), .alt_illegal_o(alt_illegal_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [3:0] a);
        logic vis;
        vis = priv_i & bank_sel_i;
        if (wr_en_i && wr_addr_i == a) return wr_data_i;
        if (a >= 8) return m_hi[a-8];
        return vis ? m_b1[a[2:0]] : m_b0[a[2:0]];
    endfunction

    function automatic string rd_tag(input logic [3:0] a);
        if (tag_ovr != "") return tag_ovr;
        if (wr_en_i && wr_addr_i == a) return "R8";
        if (a >= 8) return "R2";
        if (!priv_i) return "R3";
        return bank_sel_i ? "R4" : "R5";
    endfunction

    task automatic step(input logic pv, input logic sel,
                        input logic we, input logic [3:0] wa, input logic [31:0] wd,
                        input logic [3:0] ra, input logic [3:0] rb,
                        input logic areq, input logic awe, input logic [2:0] aa,
                        input logic [31:0] ad);
        logic vis;
        logic [31:0] aexp;
        string atag;
        @(negedge clk);
        priv_i = pv; bank_sel_i = sel; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
        rd_a_addr_i = ra; rd_b_addr_i = rb;
        alt_req_i = areq; alt_we_i = awe; alt_addr_i = aa; alt_wdata_i = ad;
        #2;
        vis = pv & sel;
        chk(rd_tag(ra), "rd_a", rd_a_data_o, model_rd(ra));
        chk(rd_tag(rb), "rd_b", rd_b_data_o, model_rd(rb));
        chk((tag_ovr != "") ? tag_ovr : "R6", "idx_r0", idx_r0_o, model_rd(4'd0));
        if (!(areq && pv)) begin
            aexp = '0; atag = "R7";
        end else if (awe) begin
            aexp = ad; atag = "R9";
        end else begin
            aexp = vis ? m_b0[aa] : m_b1[aa];
            atag = (tag_ovr != "") ? tag_ovr : (sel ? "R4" : "R5");
        end
        chk(atag, "alt_rdata", alt_rdata_o, aexp);
        chk("R7", "alt_illegal", {31'b0, alt_illegal_o}, {31'b0, areq && !pv});
        if (we) begin
            if (wa >= 8) m_hi[wa-8] = wd;
            else if (vis) m_b1[wa[2:0]] = wd;
            else m_b0[wa[2:0]] = wd;
        end
        if (areq && pv && awe) begin
            if (vis) m_b0[aa] = ad;
            else m_b1[aa] = ad;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_b0[i] = '0; m_b1[i] = '0; m_hi[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything reads zero in every view
        tag_ovr = "R1";
        for (int v = 0; v < 3; v++)
            for (int a = 0; a < 16; a += 2)
                step(v != 0, v == 2, 0, 0, 0, 4'(a), 4'(a + 1), v != 0, 0, 3'(a), 0);
        tag_ovr = "";

        // R3: user mode writes land in bank 0 regardless of select
        for (int a = 0; a < 16; a++)
            step(0, a[0], 1, 4'(a), 32'hA000_0000 + 32'(a), 4'(a), 4'(a), 0, 0, 0, 0);
        // R4: privileged, select 1 writes bank 1
        for (int a = 0; a < 8; a++)
            step(1, 1, 1, 4'(a), 32'hB100_0000 + 32'(a), 4'(a), 4'(a + 8), 1, 0, 3'(a), 0);
        // R5: alt port writes bank 1 when select 0
        for (int a = 0; a < 8; a++)
            step(1, 0, 0, 0, 0, 4'(a), 4'(a), 1, 1, 3'(a), 32'hC100_0000 + 32'(a));
        // R7: user-mode alternate writes are dropped
        for (int a = 0; a < 8; a++)
            step(0, 1, 0, 0, 0, 4'(a), 4'(a + 8), 1, 1, 3'(a), 32'hDEAD_0000);
        // R2: shared registers look the same in each view
        for (int v = 0; v < 3; v++)
            for (int a = 8; a < 16; a++)
                step(v != 0, v == 2, 0, 0, 0, 4'(a), 4'(a), 0, 0, 0, 0);

        // R10: hammer the visible copy, then look at the hidden one
        tag_ovr = "R10";
        for (int r = 0; r < 4; r++) begin
            for (int a = 0; a < 8; a++)
                step(r[0], 1, 1, 4'(a), 32'hE000_0000 + 32'(r * 16 + a), 4'(a), 4'(a), 0, 0, 0, 0);
            for (int a = 0; a < 8; a++)
                step(1, ~r[0], 0, 0, 0, 4'(a), 4'(a), 1, 0, 3'(a), 0);
            for (int a = 0; a < 8; a++)
                step(1, r[0], 0, 0, 0, 4'(a), 4'(a), 1, 0, 3'(a), 0);
        end
        tag_ovr = "";

        // Mixed random traffic
        for (int n = 0; n < 3000; n++)
            step($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 2) != 0, 4'($urandom_range(0, 15)), $urandom,
                 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                 $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                 3'($urandom_range(0, 7)), $urandom);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule